// File: doc/BRIEF.md
# I2C SCL Divider with Duty Control

This block produces the serial clock for an I2C controller by counting cycles of the source clock. A single 24-bit control word sets the timing. The low byte is the main divisor. The middle byte holds a high-speed divisor: the block stores it and presents it on an output, and it has no effect on the waveform here. The top byte is an optional high-time divisor.

With the high-time byte at zero, both halves of every SCL period last (divisor + 3) source cycles, which gives a symmetric clock for standard-mode rates. With a non-zero high-time byte, the low half lasts (divisor + 3) cycles and the high half lasts (high byte + 3) cycles. This gives the roughly one-third high, two-thirds low shape that fast modes need. For example, a word of 0x040308 from a 19.2 MHz source gives an 18-cycle period, just above 1 MHz.

The bit engine next to this block uses the single-cycle rise and fall strobes to place its data changes and samples. The control word is taken only at the start of each period, so software may rewrite it at any time without breaking the period in progress.

Top module: `scl_timebase`

## Requirements
- R1: While reset is asserted, and on every cycle the block stays disabled, `scl_o` is 1 and both strobes are 0. Reset also clears `hs_div` to 0. Reset takes priority over `enable`.
- R2: On the first clock edge at which `enable` is sampled 1 from the idle state, `scl_o` goes to 0 and `scl_fall` pulses for that first low cycle.
- R3: When bits 23:16 of the sampled word are zero, the low phase and the high phase each last (bits 7:0 + 3) clock cycles.
- R4: When bits 23:16 of the sampled word are non-zero, the low phase lasts (bits 7:0 + 3) cycles and the high phase lasts (bits 23:16 + 3) cycles.
- R5: `scl_rise` is 1 exactly in the first cycle of each high phase that follows a low phase. `scl_fall` is 1 exactly in the first cycle of each low phase. Both strobes are 0 in all other cycles, and they are never 1 together.
- R6: The control word is sampled only at the clock edge that begins a low phase. A change at any other time takes effect at the start of the next period.
- R7: When `enable` is sampled 0 during any phase, `scl_o` is 1 from the next cycle, with no strobe. A later enable restarts with a full-length low phase.
- R8: `hs_div` shows bits 15:8 of the word sampled at the most recent period start. It changes only at those edges and never alters the phase lengths.
- R9: The extreme divisors are handled without wrap: a divisor of 0 gives 3-cycle phases, and a divisor of 255 gives 258-cycle phases.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Run the clock generator |
| ctl_word | input | 24 | Timing word: [7:0] main divisor, [15:8] high-speed divisor, [23:16] high-time divisor |
| scl_o | output | 1 | Generated SCL level, 1 = released |
| scl_rise | output | 1 | One-cycle strobe at the start of a high phase |
| scl_fall | output | 1 | One-cycle strobe at the start of a low phase |
| hs_div | output | 8 | Stored high-speed divisor |

## Verification
The hardest situation to reach from the ports is a control word that changes partway through a period. The new value must not shorten or stretch the phase in progress, and it must take hold exactly at the next fall. The stimulus writes a second word in the very first low cycle after a start. It then measures one whole period that must follow the old lengths, and a second period that must follow the new ones, and it checks `hs_div` at each boundary. A second awkward case is a disable that lands in the middle of a high phase followed by an immediate restart. This case is driven directly, and the bench confirms that the restarted low phase has its full length.

// File: rtl/scl_div_pkg.sv
// Package: shared phase encoding for the SCL divider.
// Assumes: nothing beyond the phase set below.
package scl_div_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_HIGH = 2'd2
    } scl_phase_e;
endpackage

// File: rtl/scl_div_cfg.sv
// Module: holds the timing word fields and derives the phase lengths.
// Assumes: load pulses only at the edge that starts a low phase, so the
// lengths stay constant for a whole period.
module scl_div_cfg #(
    parameter int DIV_W         = 8,
    parameter int OFFSET        = 3,
    parameter bit HIGH_FIELD_EN = 1'b1,
    parameter int LEN_W         = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [3*DIV_W-1:0] word_i,
    output logic [LEN_W-1:0]   low_len_o,
    output logic [LEN_W-1:0]   high_len_o,
    output logic [DIV_W-1:0]   hs_div_o
);
    localparam logic [LEN_W-1:0] OFS = LEN_W'(OFFSET);

    logic [DIV_W-1:0] low_q;
    logic [DIV_W-1:0] hs_q;

    // Capture the main and high-speed divisors at each period start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q <= '0;
            hs_q  <= '0;
        end else if (load) begin
            low_q <= word_i[DIV_W-1:0];
            hs_q  <= word_i[2*DIV_W-1:DIV_W];
        end
    end

    // Low phase length: main divisor plus the fixed offset.
    always_comb begin
        low_len_o = LEN_W'(low_q) + OFS;
    end

    assign hs_div_o = hs_q;

    generate
        if (HIGH_FIELD_EN) begin : g_asym
            logic [DIV_W-1:0] hi_q;

            // Capture the high-time divisor together with the others.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hi_q <= '0;
                end else if (load) begin
                    hi_q <= word_i[3*DIV_W-1:2*DIV_W];
                end
            end

            // High phase length: a zero field selects symmetric timing.
            always_comb begin
                if (hi_q == '0) begin
                    high_len_o = LEN_W'(low_q) + OFS;
                end else begin
                    high_len_o = LEN_W'(hi_q) + OFS;
                end
            end
        end else begin : g_sym
            // High phase length equals low phase length in symmetric builds.
            always_comb begin
                high_len_o = LEN_W'(low_q) + OFS;
            end
        end
    endgenerate
endmodule

// File: rtl/scl_div_seq.sv
// Module: phase sequencer and cycle counter for the SCL divider.
// Assumes: lengths are at least 1 and stay stable while a phase runs.
module scl_div_seq
    import scl_div_pkg::*;
#(
    parameter int LEN_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [LEN_W-1:0] low_len_i,
    input  logic [LEN_W-1:0] high_len_i,
    output scl_phase_e       phase_o,
    output scl_phase_e       phase_nxt_o,
    output logic             load_o
);
    scl_phase_e       phase_q;
    scl_phase_e       phase_d;
    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] cur_len;
    logic             last;

    // Select the length of the running phase and flag its final cycle.
    always_comb begin
        cur_len = (phase_q == PH_HIGH) ? high_len_i : low_len_i;
        last    = (cnt_q == cur_len - LEN_W'(1));
    end

    // Next-phase decision.
    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_IDLE: if (enable) phase_d = PH_LOW;
            PH_LOW: begin
                if (!enable)   phase_d = PH_IDLE;
                else if (last) phase_d = PH_HIGH;
            end
            PH_HIGH: begin
                if (!enable)   phase_d = PH_IDLE;
                else if (last) phase_d = PH_LOW;
            end
            default: phase_d = PH_IDLE;
        endcase
    end

    // A new period begins whenever a low phase is entered.
    assign load_o      = (phase_d == PH_LOW) && (phase_q != PH_LOW);
    assign phase_o     = phase_q;
    assign phase_nxt_o = phase_d;

    // Phase register and in-phase cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_d;
            if (phase_d != phase_q || phase_d == PH_IDLE) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + LEN_W'(1);
            end
        end
    end
endmodule

// File: rtl/scl_div_out.sv
// Module: registers the SCL level and the phase-boundary strobes.
// Assumes: phase_i/phase_nxt_i come from the same sequencer, so the outputs
// line up with its phase register.
module scl_div_out
    import scl_div_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  scl_phase_e phase_i,
    input  scl_phase_e phase_nxt_i,
    output logic       scl_o,
    output logic       rise_o,
    output logic       fall_o
);
    // Drive SCL low only in the low phase; pulse strobes on phase entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_o  <= 1'b1;
            rise_o <= 1'b0;
            fall_o <= 1'b0;
        end else begin
            scl_o  <= (phase_nxt_i != PH_LOW);
            rise_o <= (phase_nxt_i == PH_HIGH) && (phase_i == PH_LOW);
            fall_o <= (phase_nxt_i == PH_LOW) && (phase_i != PH_LOW);
        end
    end
endmodule

// File: rtl/scl_timebase.sv
// Module: top of the I2C SCL divider with symmetric or fast-mode duty.
// Assumes: clk is the source clock; the control word may change at any time
// and is taken only at period starts.
module scl_timebase
    import scl_div_pkg::*;
#(
    parameter int DIV_W         = 8,
    parameter int OFFSET        = 3,
    parameter bit HIGH_FIELD_EN = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic [3*DIV_W-1:0] ctl_word,
    output logic               scl_o,
    output logic               scl_rise,
    output logic               scl_fall,
    output logic [DIV_W-1:0]   hs_div
);
    localparam int LEN_W = $clog2((1 << DIV_W) + OFFSET);

    logic [LEN_W-1:0] low_len;
    logic [LEN_W-1:0] high_len;
    logic             load;
    scl_phase_e       phase;
    scl_phase_e       phase_nxt;

    scl_div_cfg #(
        .DIV_W(DIV_W), .OFFSET(OFFSET),
        .HIGH_FIELD_EN(HIGH_FIELD_EN), .LEN_W(LEN_W)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(load), .word_i(ctl_word),
        .low_len_o(low_len), .high_len_o(high_len), .hs_div_o(hs_div)
    );

    scl_div_seq #(.LEN_W(LEN_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .low_len_i(low_len), .high_len_i(high_len),
        .phase_o(phase), .phase_nxt_o(phase_nxt), .load_o(load)
    );

    scl_div_out u_out (
        .clk(clk), .rst_n(rst_n), .phase_i(phase), .phase_nxt_i(phase_nxt),
        .scl_o(scl_o), .rise_o(scl_rise), .fall_o(scl_fall)
    );
endmodule

// File: rtl/scl_div_chk.sv
// Module: protocol checker for scl_timebase, attached with bind.
// Assumes: observes top-level ports only.
module scl_div_chk #(
    parameter int DIV_W  = 8,
    parameter int OFFSET = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             scl_o,
    input logic             scl_rise,
    input logic             scl_fall,
    input logic [DIV_W-1:0] hs_div
);
    localparam int RUN_W = $clog2((1 << DIV_W) + OFFSET) + 1;
    localparam logic [RUN_W-1:0] RUN_MAX = '1;

    logic [RUN_W-1:0] low_run;

    // Count consecutive low cycles of SCL, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_run <= '0;
        end else if (!scl_o) begin
            if (low_run != RUN_MAX) low_run <= low_run + RUN_W'(1);
        end else begin
            low_run <= '0;
        end
    end

    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (scl_o && !scl_rise && !scl_fall));
    p_fall_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
        scl_fall |-> (!scl_o && $past(scl_o)));
    p_rise_level_r5: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise |-> (scl_o && !$past(scl_o)));
    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(scl_rise && scl_fall));
    p_fall_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_o) |-> scl_fall);
    p_min_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        scl_rise |-> (low_run >= RUN_W'(OFFSET)));
    p_hs_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !scl_fall |-> $stable(hs_div));
endmodule

bind scl_timebase scl_div_chk #(.DIV_W(DIV_W), .OFFSET(OFFSET)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable(enable), .scl_o(scl_o),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .hs_div(hs_div)
);

// File: tb/test_scl_timebase.sv
module test_scl_timebase;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [23:0] ctl_word = '0;
    logic        scl_o, scl_rise, scl_fall;
    logic [7:0]  hs_div;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    scl_timebase i_scl_timebase (
        .clk(clk), .rst_n(rst_n), .enable(enable), .ctl_word(ctl_word),
        .scl_o(scl_o), .scl_rise(scl_rise), .scl_fall(scl_fall), .hs_div(hs_div)
    );

    function automatic int exp_low(input logic [23:0] w);
        return int'(w[7:0]) + 3;
    endfunction

    function automatic int exp_high(input logic [23:0] w);
        return (w[23:16] == 8'd0) ? int'(w[7:0]) + 3 : int'(w[23:16]) + 3;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Start from idle: first low cycle must follow (R2), hs_div updated (R8).
    task automatic start(input logic [23:0] w);
        @(negedge clk);
        ctl_word = w;
        enable   = 1'b1;
        @(negedge clk);
        check(scl_o === 1'b0, "R2", int'(scl_o), 0);
        check(scl_fall === 1'b1, "R2", int'(scl_fall), 1);
        check(hs_div === w[15:8], "R8", int'(hs_div), int'(w[15:8]));
    endtask

    // Measure a phase starting at its first cycle; ends at next phase's first cycle.
    task automatic meas(input bit lvl, input int exp_len, input string req);
        int len = 1;
        bit quiet = 1'b1;
        for (int k = 0; k < 1000; k++) begin
            @(negedge clk);
            if (scl_o !== lvl) break;
            len++;
            if (scl_rise || scl_fall) quiet = 1'b0;
        end
        check(len == exp_len, req, len, exp_len);
        check(quiet, "R5", int'(quiet), 1);
        if (lvl) check(scl_fall === 1'b1, "R5", int'(scl_fall), 1);
        else     check(scl_rise === 1'b1 && scl_o === 1'b1, "R5", int'(scl_rise), 1);
    endtask

    // Drop enable at the current negedge and confirm SCL released (R7, R1).
    task automatic stop();
        enable = 1'b0;
        @(negedge clk);
        check(scl_o === 1'b1 && !scl_rise && !scl_fall, "R7", int'(scl_o), 1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(scl_o === 1'b1 && !scl_rise && !scl_fall, "R1", int'(scl_o), 1);
        end
    endtask

    task automatic run_word(input logic [23:0] w, input int periods, input string req);
        start(w);
        for (int p = 0; p < periods; p++) begin
            meas(1'b0, exp_low(w), req);
            meas(1'b1, exp_high(w), req);
        end
        stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [23:0] w;
        void'($urandom(32'd20240611));
        // R1: reset dominates enable.
        enable = 1'b1;
        ctl_word = 24'h123456;
        repeat (3) @(negedge clk);
        check(scl_o === 1'b1 && !scl_rise && !scl_fall, "R1", int'(scl_o), 1);
        check(hs_div === 8'h00, "R1", int'(hs_div), 0);
        enable = 1'b0;
        rst_n  = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            check(scl_o === 1'b1 && !scl_rise && !scl_fall, "R1", int'(scl_o), 1);
        end

        // R3 / R4 directed.
        run_word(24'h00_07_0A, 2, "R3");
        run_word(24'h04_03_08, 2, "R4");
        // R9 extremes.
        run_word(24'h00_00_00, 2, "R9");
        run_word(24'h00_00_FF, 1, "R9");
        run_word(24'hFF_00_00, 1, "R9");

        // R6 / R8: word rewritten inside the first low cycle.
        start(24'h05_11_0A);
        ctl_word = 24'h00_22_04;
        meas(1'b0, 13, "R6");
        check(hs_div === 8'h11, "R8", int'(hs_div), 8'h11);
        meas(1'b1, 8, "R6");
        check(hs_div === 8'h22, "R8", int'(hs_div), 8'h22);
        meas(1'b0, 7, "R6");
        meas(1'b1, 7, "R6");
        stop();

        // R7: disable inside a high phase, then restart with full low.
        start(24'h06_00_05);
        meas(1'b0, 8, "R7");
        repeat (2) @(negedge clk);
        stop();
        start(24'h06_00_05);
        meas(1'b0, 8, "R7");
        meas(1'b1, 9, "R7");
        stop();

        // Random words, mixing symmetric and asymmetric modes.
        for (int it = 0; it < 16; it++) begin
            w = 24'($urandom);
            if ($urandom % 3 == 0) w[23:16] = 8'd0;
            run_word(w, 2, (w[23:16] == 8'd0) ? "R3" : "R4");
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule